// File: doc/BRIEF.md
# Flash Access Guard

This block sits between the bus masters and an embedded flash array of 128 pages of 2 KB each. Every cycle it classifies the presented request by master and by operation. It then decides at once whether the array may act on the request. The decision combines the current protection level, the boot and debug context, page-granular program/erase fences, and an execute-only window in which only CPU instruction fetches may read.

A denied request does not reach the array. One cycle later it produces a single violation pulse and sets a sticky error flag that software clears. Read data is returned through the guard. It is forced to zero unless the read was granted.

The block also holds the protection level. A request to move from the locked level back to the open level starts a page-by-page wipe of the array. The wipe can leave out the pages that hold execute-only code. The level drops to open only when the last page has been handled.

Top module: `flash_guard`

## Requirements
- R1: After reset the level reads 0 (open), `viol_pulse`, `viol_flag`, `ers_busy`, `ers_pg_valid` and `ers_done` are all low, and `rsp_rdata` is zero.
- R2: At level 0 with no fence or window hit, every master may read, and the data masters (01 CPU data, 10 DMA, 11 debug) may program. Masters are coded 00 CPU fetch, 01 CPU data, 10 DMA, 11 debug. Operations are coded 00 read, 01 program, 10 page erase, 11 mass erase.
- R3: At level 1, any request from any master is denied while `dbg_attached`, `boot_ram` or `boot_loader` is high. With all three low, requests are judged by the other rules.
- R4: At level 2, every debug-master (11) request is denied. `dbg_attached`, `boot_ram` and `boot_loader` have no effect on the other masters.
- R5: A level request (`lvl_req` with `lvl_val`) may raise the level from 0 to 1 or 2, or from 1 to 2. The new value appears on `level` in the cycle after the request. Code 3, any request at level 2, and any request while a wipe runs are ignored.
- R6: Fence area g covers pages `wrp_lo[g]` to `wrp_hi[g]` inclusive. The page index is address bits [17:11]. A program or page erase that targets a covered page is denied, and reads there are allowed. An area with lo greater than hi covers nothing.
- R7: The execute-only window covers 64-bit words `xo_lo` to `xo_hi` inclusive. The word index is address bits [17:3]. Within the window only CPU-fetch reads are granted. A program inside the window is denied, and so is a page erase of any page that overlaps it. The CPU-fetch master is denied every operation other than read.
- R8: A mass erase request is denied whenever any fence area or the execute-only window is active.
- R9: `viol_pulse` is high in the cycle after a denied request, for that one cycle. `viol_flag` sets at the same time and stays set until `err_clr`. A new denial in the same cycle as `err_clr` keeps the flag set.
- R10: In the cycle after a granted read, `rsp_rdata` equals `arr_rdata`. In every other cycle, including the cycle after a denied read, it is zero.
- R11: A request to go from level 1 to 0 raises `ers_busy` for 128 cycles, with `ers_pg` counting 0 to 127, one page per cycle. All requests are denied during the wipe and the level stays 1. After the wipe, `level` is 0 and `ers_done` is high.
- R12: With `xo_keep` high, pages that overlap an active execute-only window get no `ers_pg_valid` during a wipe. With `xo_keep` low, all 128 pages are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 1 | Level change request strobe |
| lvl_val | input | 2 | Requested level |
| xo_keep | input | 1 | Keep execute-only pages during the wipe |
| dbg_attached | input | 1 | Debugger connected |
| boot_ram | input | 1 | Booted from RAM |
| boot_loader | input | 1 | Booted from the loader |
| wrp_lo | input | 14 | First page of each fence area, area g at [7g+6:7g] |
| wrp_hi | input | 14 | Last page of each fence area |
| xo_lo | input | 15 | First 64-bit word of the execute-only window |
| xo_hi | input | 15 | Last 64-bit word of the execute-only window |
| req_valid | input | 1 | Request present |
| req_master | input | 2 | Master code |
| req_op | input | 2 | Operation code |
| req_addr | input | 18 | Byte address |
| arr_rdata | input | 64 | Read data from the array, one cycle after the request |
| err_clr | input | 1 | Clears the sticky error flag |
| acc_grant | output | 1 | Request allowed (same cycle) |
| viol_pulse | output | 1 | One-cycle pulse for a denied request |
| viol_flag | output | 1 | Sticky error flag |
| rsp_rdata | output | 64 | Gated read data |
| level | output | 2 | Current protection level |
| ers_busy | output | 1 | Wipe in progress |
| ers_pg_valid | output | 1 | Erase the page on `ers_pg` this cycle |
| ers_pg | output | 7 | Page index during the wipe |
| ers_done | output | 1 | Last wipe finished |

## Verification
Every cycle, the assertions check that a violation pulse follows a denied request and that read data stays zero unless a read was granted. They also check that level 2 never changes, that debug access is refused at level 2, and that the wipe steps through pages one at a time while refusing traffic. Which requests are refused inside fences and the execute-only window depends on the context, so only the bench scenarios can show it. The same holds for the pages skipped by the keep option and for the level reached after a wipe.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [1:0] {
      MST_FETCH = 2'b00,
      MST_DATA  = 2'b01,
      MST_DMA   = 2'b10,
      MST_DEBUG = 2'b11
   } fg_master_e;

   typedef enum logic [1:0] {
      OP_READ   = 2'b00,
      OP_PROG   = 2'b01,
      OP_PERASE = 2'b10,
      OP_MERASE = 2'b11
   } fg_op_e;

   typedef enum logic [1:0] {
      LVL_OPEN = 2'd0,
      LVL_LOCK = 2'd1,
      LVL_SEAL = 2'd2,
      LVL_BAD  = 2'd3
   } fg_level_e;

   typedef enum logic {
      SQ_IDLE  = 1'b0,
      SQ_ERASE = 1'b1
   } fg_seq_e;
endpackage

// File: rtl/fg_span_hit.sv
// Inclusive range overlap: [lo,hi] against [pt_lo,pt_hi]; lo > hi means empty.
module fg_span_hit #(
   parameter int W = 8
) (
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] pt_lo,
   input  logic [W-1:0] pt_hi,
   output logic         active,
   output logic         hit
);
   assign active = (lo <= hi);
   assign hit    = active && (lo <= pt_hi) && (hi >= pt_lo);
endmodule

// File: rtl/fg_access_policy.sv
// Pure decision logic; rule order encodes precedence.
module fg_access_policy
   import fg_pkg::*;
(
   input  fg_level_e  level,
   input  logic       busy,
   input  logic       ctx_untrusted,
   input  fg_master_e master,
   input  fg_op_e     op,
   input  logic       wrp_hit,
   input  logic       wrp_any,
   input  logic       xo_word_hit,
   input  logic       xo_page_hit,
   input  logic       xo_any,
   output logic       allow
);
   always_comb begin
      allow = 1'b1;
      if (busy) begin
         allow = 1'b0;
      end else if (level == LVL_SEAL && master == MST_DEBUG) begin
         allow = 1'b0;
      end else if (level == LVL_LOCK && ctx_untrusted) begin
         allow = 1'b0;
      end else if (master == MST_FETCH && op != OP_READ) begin
         allow = 1'b0;
      end else begin
         case (op)
            OP_READ:   allow = !(xo_word_hit && master != MST_FETCH);
            OP_PROG:   allow = !(wrp_hit || xo_word_hit);
            OP_PERASE: allow = !(wrp_hit || xo_page_hit);
            default:   allow = !(wrp_any || xo_any);
         endcase
      end
   end
endmodule

// File: rtl/fg_regress_seq.sv
// Holds the protection level and walks the array on a lock-to-open regression.
module fg_regress_seq
   import fg_pkg::*;
#(
   parameter int        PAGES     = 128,
   parameter int        PG_W      = 7,
   parameter int        WPP_SH    = 8,
   parameter fg_level_e RST_LEVEL = LVL_OPEN,
   localparam int       WD_W      = PG_W + WPP_SH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lvl_req,
   input  logic [1:0]      lvl_val,
   input  logic            xo_keep,
   input  logic [WD_W-1:0] xo_lo,
   input  logic [WD_W-1:0] xo_hi,
   output fg_level_e       level,
   output logic            busy,
   output logic [PG_W-1:0] pg,
   output logic            pg_valid,
   output logic            done
);
   localparam logic [PG_W-1:0] LAST_PG = PG_W'(PAGES - 1);

   fg_seq_e         state_q;
   fg_level_e       level_q;
   logic [PG_W-1:0] pg_q;
   logic            done_q;
   logic            pg_in_xo;
   logic            xo_act_unused;

   fg_span_hit #(.W(WD_W)) u_pg_xo (
      .lo     (xo_lo),
      .hi     (xo_hi),
      .pt_lo  ({pg_q, {WPP_SH{1'b0}}}),
      .pt_hi  ({pg_q, {WPP_SH{1'b1}}}),
      .active (xo_act_unused),
      .hit    (pg_in_xo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         level_q <= RST_LEVEL;
         pg_q    <= '0;
         done_q  <= 1'b0;
      end else if (state_q == SQ_ERASE) begin
         if (pg_q == LAST_PG) begin
            state_q <= SQ_IDLE;
            level_q <= LVL_OPEN;
            done_q  <= 1'b1;
            pg_q    <= '0;
         end else begin
            pg_q <= pg_q + 1'b1;
         end
      end else if (lvl_req) begin
         case (level_q)
            LVL_OPEN: begin
               if (lvl_val == LVL_LOCK || lvl_val == LVL_SEAL)
                  level_q <= fg_level_e'(lvl_val);
            end
            LVL_LOCK: begin
               if (lvl_val == LVL_OPEN) begin
                  state_q <= SQ_ERASE;
                  pg_q    <= '0;
                  done_q  <= 1'b0;
               end else if (lvl_val == LVL_SEAL) begin
                  level_q <= LVL_SEAL;
               end
            end
            default: ;
         endcase
      end
   end

   assign level    = level_q;
   assign busy     = (state_q == SQ_ERASE);
   assign pg       = pg_q;
   assign pg_valid = busy && !(xo_keep && pg_in_xo);
   assign done     = done_q;
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fg_pkg::*;
#(
   parameter int        PAGES      = 128,
   parameter int        PAGE_BYTES = 2048,
   parameter int        XO_BYTES   = 8,
   parameter int        DATA_W     = 64,
   parameter int        WRP_AREAS  = 2,
   parameter bit        XO_ZONE_EN = 1'b1,
   parameter fg_level_e RST_LEVEL  = LVL_OPEN,
   localparam int       PG_W       = $clog2(PAGES),
   localparam int       OFS_W      = $clog2(PAGE_BYTES),
   localparam int       ADDR_W     = PG_W + OFS_W,
   localparam int       XO_SH      = $clog2(XO_BYTES),
   localparam int       WD_W       = ADDR_W - XO_SH,
   localparam int       WPP_SH     = OFS_W - XO_SH
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lvl_req,
   input  logic [1:0]                lvl_val,
   input  logic                      xo_keep,
   input  logic                      dbg_attached,
   input  logic                      boot_ram,
   input  logic                      boot_loader,
   input  logic [WRP_AREAS*PG_W-1:0] wrp_lo,
   input  logic [WRP_AREAS*PG_W-1:0] wrp_hi,
   input  logic [WD_W-1:0]           xo_lo,
   input  logic [WD_W-1:0]           xo_hi,
   input  logic                      req_valid,
   input  logic [1:0]                req_master,
   input  logic [1:0]                req_op,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [DATA_W-1:0]         arr_rdata,
   input  logic                      err_clr,
   output logic                      acc_grant,
   output logic                      viol_pulse,
   output logic                      viol_flag,
   output logic [DATA_W-1:0]         rsp_rdata,
   output logic [1:0]                level,
   output logic                      ers_busy,
   output logic                      ers_pg_valid,
   output logic [PG_W-1:0]           ers_pg,
   output logic                      ers_done
);
   // elaboration-time parameter checks
   if ((1 << PG_W) != PAGES) begin : g_bad_pages
      $error("PAGES must be a power of two");
   end
   if ((1 << OFS_W) != PAGE_BYTES || (1 << XO_SH) != XO_BYTES) begin : g_bad_sizes
      $error("PAGE_BYTES and XO_BYTES must be powers of two");
   end
   if (XO_BYTES > PAGE_BYTES || WRP_AREAS < 1) begin : g_bad_geom
      $error("window granule must fit a page and at least one fence area is needed");
   end

   // request decomposition
   logic [PG_W-1:0] req_pg;
   logic [WD_W-1:0] req_wd;
   assign req_pg = req_addr[ADDR_W-1:OFS_W];
   assign req_wd = req_addr[ADDR_W-1:XO_SH];

   // effective execute-only bounds: variant chosen by parameter
   logic [WD_W-1:0] xo_lo_e, xo_hi_e;
   if (XO_ZONE_EN) begin : g_xo_on
      assign xo_lo_e = xo_lo;
      assign xo_hi_e = xo_hi;
   end else begin : g_xo_off
      assign xo_lo_e = '1;
      assign xo_hi_e = '0;
   end

   // fence areas
   logic [WRP_AREAS-1:0] wrp_hit_v, wrp_act_v;
   for (genvar g = 0; g < WRP_AREAS; g++) begin : g_wrp
      fg_span_hit #(.W(PG_W)) u_span (
         .lo     (wrp_lo[g*PG_W +: PG_W]),
         .hi     (wrp_hi[g*PG_W +: PG_W]),
         .pt_lo  (req_pg),
         .pt_hi  (req_pg),
         .active (wrp_act_v[g]),
         .hit    (wrp_hit_v[g])
      );
   end

   // execute-only window: word hit and whole-page overlap
   logic xo_word_hit, xo_page_hit, xo_any, xo_any_dup;
   fg_span_hit #(.W(WD_W)) u_xo_word (
      .lo     (xo_lo_e),
      .hi     (xo_hi_e),
      .pt_lo  (req_wd),
      .pt_hi  (req_wd),
      .active (xo_any),
      .hit    (xo_word_hit)
   );
   fg_span_hit #(.W(WD_W)) u_xo_page (
      .lo     (xo_lo_e),
      .hi     (xo_hi_e),
      .pt_lo  ({req_pg, {WPP_SH{1'b0}}}),
      .pt_hi  ({req_pg, {WPP_SH{1'b1}}}),
      .active (xo_any_dup),
      .hit    (xo_page_hit)
   );

   // level holder and regression walker
   fg_level_e lvl_cur;
   fg_regress_seq #(
      .PAGES     (PAGES),
      .PG_W      (PG_W),
      .WPP_SH    (WPP_SH),
      .RST_LEVEL (RST_LEVEL)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_req  (lvl_req),
      .lvl_val  (lvl_val),
      .xo_keep  (xo_keep),
      .xo_lo    (xo_lo_e),
      .xo_hi    (xo_hi_e),
      .level    (lvl_cur),
      .busy     (ers_busy),
      .pg       (ers_pg),
      .pg_valid (ers_pg_valid),
      .done     (ers_done)
   );

   // decision
   logic allow;
   fg_access_policy u_pol (
      .level         (lvl_cur),
      .busy          (ers_busy),
      .ctx_untrusted (dbg_attached | boot_ram | boot_loader),
      .master        (fg_master_e'(req_master)),
      .op            (fg_op_e'(req_op)),
      .wrp_hit       (|wrp_hit_v),
      .wrp_any       (|wrp_act_v),
      .xo_word_hit   (xo_word_hit),
      .xo_page_hit   (xo_page_hit),
      .xo_any        (xo_any),
      .allow         (allow)
   );

   assign acc_grant = req_valid && allow;

   // registered response side
   logic viol_q, flag_q, rd_ok_q;
   logic deny_now;
   assign deny_now = req_valid && !allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_q  <= 1'b0;
         flag_q  <= 1'b0;
         rd_ok_q <= 1'b0;
      end else begin
         viol_q  <= deny_now;
         rd_ok_q <= acc_grant && (req_op == OP_READ);
         if (deny_now)     flag_q <= 1'b1;
         else if (err_clr) flag_q <= 1'b0;
      end
   end

   assign viol_pulse = viol_q;
   assign viol_flag  = flag_q;
   assign rsp_rdata  = rd_ok_q ? arr_rdata : '0;
   assign level      = lvl_cur;
endmodule

// File: rtl/fg_guard_chk.sv
module fg_guard_chk #(
   parameter int DATA_W = 64,
   parameter int PG_W   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_master,
   input logic [1:0]        req_op,
   input logic              acc_grant,
   input logic              viol_pulse,
   input logic              viol_flag,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [1:0]        level,
   input logic              ers_busy,
   input logic              ers_pg_valid,
   input logic [PG_W-1:0]   ers_pg,
   input logic              ers_done
);
   logic past_v;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_v <= 1'b0;
      else        past_v <= 1'b1;
   end

   p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      past_v && viol_pulse |-> $past(req_valid && !acc_grant));
   p_flag_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> viol_flag);
   p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      past_v && $rose(viol_flag) |-> viol_pulse);
   p_rdata_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      past_v && !$past(req_valid && acc_grant && req_op == 2'b00) |-> rsp_rdata == '0);
   p_seal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      past_v && $past(level) == 2'd2 |-> level == 2'd2);
   p_dbg_sealed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      level == 2'd2 && req_valid && req_master == 2'b11 |-> !acc_grant);
   p_busy_deny_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ers_busy && req_valid |-> !acc_grant);
   p_pg_valid_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ers_pg_valid |-> ers_busy);
   p_pg_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      past_v && ers_busy && $past(ers_busy) |-> ers_pg == PG_W'($past(ers_pg) + 1'b1));
   p_done_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
      past_v && $rose(ers_done) |-> level == 2'd0);
endmodule

bind flash_guard fg_guard_chk #(.DATA_W(DATA_W), .PG_W(PG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_master   (req_master),
   .req_op       (req_op),
   .acc_grant    (acc_grant),
   .viol_pulse   (viol_pulse),
   .viol_flag    (viol_flag),
   .rsp_rdata    (rsp_rdata),
   .level        (level),
   .ers_busy     (ers_busy),
   .ers_pg_valid (ers_pg_valid),
   .ers_pg       (ers_pg),
   .ers_done     (ers_done)
);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
   localparam logic [63:0] ARR = 64'hA5A5_1234_DEAD_BEEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lvl_req = 1'b0;
   logic [1:0]  lvl_val = '0;
   logic        xo_keep = 1'b0;
   logic        dbg_attached = 1'b0, boot_ram = 1'b0, boot_loader = 1'b0;
   logic [13:0] wrp_lo = {7'd1, 7'd1};
   logic [13:0] wrp_hi = {7'd0, 7'd0};
   logic [14:0] xo_lo = 15'd1, xo_hi = 15'd0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_master = '0, req_op = '0;
   logic [17:0] req_addr = '0;
   logic [63:0] arr_rdata = ARR;
   logic        err_clr = 1'b0;
   logic        acc_grant, viol_pulse, viol_flag;
   logic [63:0] rsp_rdata;
   logic [1:0]  level;
   logic        ers_busy, ers_pg_valid, ers_done;
   logic [6:0]  ers_pg;

   flash_guard u0 (.*);

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      int          due;
      logic        pulse;
      logic [63:0] data;
      string       tag;
   } sb_t;
   sb_t sbq[$];
   sb_t mon_it;

   always @(negedge clk) begin
      #2;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         mon_it = sbq.pop_front();
         chk(viol_pulse === mon_it.pulse, {mon_it.tag, " pulse"}, 64'(viol_pulse), 64'(mon_it.pulse));
         chk(rsp_rdata === mon_it.data, {mon_it.tag, " rdata"}, rsp_rdata, mon_it.data);
      end
   end

   // page monitor
   int pg_cnt = 0, last_pg = -1;
   bit order_bad = 1'b0, saw_xo_pg = 1'b0;
   always @(negedge clk) begin
      #1;
      if (ers_pg_valid) begin
         if (int'(ers_pg) <= last_pg) order_bad = 1'b1;
         if (ers_pg == 7'd16 || ers_pg == 7'd17) saw_xo_pg = 1'b1;
         last_pg = int'(ers_pg);
         pg_cnt++;
      end
   end

   task automatic issue(input logic [1:0] m, input logic [1:0] op, input logic [17:0] a,
                        input logic exp_ok, input string tag);
      sb_t it;
      @(negedge clk);
      req_valid = 1'b1; req_master = m; req_op = op; req_addr = a;
      #1;
      chk(acc_grant === exp_ok, {tag, " grant"}, 64'(acc_grant), 64'(exp_ok));
      it.due = cyc + 1; it.pulse = !exp_ok;
      it.data = (exp_ok && op == 2'b00) ? ARR : 64'h0;
      it.tag = tag;
      sbq.push_back(it);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic set_level(input logic [1:0] v);
      @(negedge clk);
      lvl_req = 1'b1; lvl_val = v;
      @(negedge clk);
      lvl_req = 1'b0;
      #1;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 400 && ers_busy; n++) @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(level == 2'd0, "R1 level", 64'(level), 0);
      chk(!viol_pulse && !viol_flag, "R1 violation", 64'({viol_pulse, viol_flag}), 0);
      chk(!ers_busy && !ers_pg_valid && !ers_done, "R1 wipe", 64'({ers_busy, ers_pg_valid, ers_done}), 0);
      chk(rsp_rdata == 64'h0, "R1 rdata", rsp_rdata, 0);

      // R2 open level, R10 data pass-through
      issue(2'b01, 2'b00, 18'h00100, 1'b1, "R2 data read");
      issue(2'b00, 2'b00, 18'h00108, 1'b1, "R2 fetch read");
      issue(2'b11, 2'b00, 18'h00110, 1'b1, "R2 debug read");
      issue(2'b10, 2'b01, 18'h00200, 1'b1, "R2 dma program");
      issue(2'b11, 2'b10, 18'h00800, 1'b1, "R2 debug page erase");
      chk(!viol_flag, "R2 no flag", 64'(viol_flag), 0);

      // R6 fence area 0 = pages 4..6, area 1 empty
      wrp_lo = {7'd1, 7'd4}; wrp_hi = {7'd0, 7'd6};
      issue(2'b01, 2'b01, 18'h02800, 1'b0, "R6 program page5");
      @(negedge clk); #3;
      chk(viol_flag, "R9 flag set", 64'(viol_flag), 1);
      issue(2'b10, 2'b00, 18'h02800, 1'b1, "R6 read page5");
      issue(2'b01, 2'b10, 18'h03000, 1'b0, "R6 erase page6");
      issue(2'b01, 2'b01, 18'h03800, 1'b1, "R6 program page7");
      issue(2'b01, 2'b10, 18'h01FF8, 1'b1, "R6 erase page3");
      issue(2'b01, 2'b11, 18'h00000, 1'b0, "R8 mass erase fence");
      // R9 clear, then clear with simultaneous denial
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
      #3 chk(!viol_flag, "R9 flag cleared", 64'(viol_flag), 0);
      @(negedge clk);
      err_clr = 1'b1; req_valid = 1'b1; req_master = 2'b01; req_op = 2'b01; req_addr = 18'h02000;
      @(negedge clk);
      err_clr = 1'b0; req_valid = 1'b0;
      #3 chk(viol_flag && viol_pulse, "R9 set wins", 64'({viol_flag, viol_pulse}), 64'(3));
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
      wrp_lo = {7'd1, 7'd1}; wrp_hi = {7'd0, 7'd0};
      issue(2'b01, 2'b11, 18'h00000, 1'b1, "R8 mass erase open");

      // R7 execute-only window words 0x10F0..0x1100 (pages 16 and 17)
      xo_lo = 15'h10F0; xo_hi = 15'h1100;
      issue(2'b00, 2'b00, 18'h08780, 1'b1, "R7 fetch read window");
      issue(2'b01, 2'b00, 18'h08780, 1'b0, "R7 data read window");
      issue(2'b10, 2'b00, 18'h08800, 1'b0, "R7 dma read window end");
      issue(2'b11, 2'b00, 18'h08780, 1'b0, "R7 debug read window");
      issue(2'b01, 2'b01, 18'h08800, 1'b0, "R7 program window");
      issue(2'b01, 2'b01, 18'h08808, 1'b1, "R7 program past window");
      issue(2'b01, 2'b00, 18'h08778, 1'b1, "R7 read before window");
      issue(2'b10, 2'b10, 18'h08000, 1'b0, "R7 erase page16");
      issue(2'b10, 2'b10, 18'h08800, 1'b0, "R7 erase page17");
      issue(2'b10, 2'b10, 18'h09000, 1'b1, "R7 erase page18");
      issue(2'b00, 2'b01, 18'h00100, 1'b0, "R7 fetch program");
      issue(2'b01, 2'b11, 18'h00000, 1'b0, "R8 mass erase window");

      // R5 code 3 ignored, raise to 1
      set_level(2'd3);
      chk(level == 2'd0, "R5 code3 ignored", 64'(level), 0);
      set_level(2'd1);
      chk(level == 2'd1, "R5 raise to 1", 64'(level), 1);

      // R3 untrusted contexts at level 1
      dbg_attached = 1'b1;
      issue(2'b01, 2'b00, 18'h00100, 1'b0, "R3 debugger read");
      dbg_attached = 1'b0; boot_ram = 1'b1;
      issue(2'b00, 2'b00, 18'h00100, 1'b0, "R3 boot ram fetch");
      boot_ram = 1'b0; boot_loader = 1'b1;
      issue(2'b10, 2'b01, 18'h00100, 1'b0, "R3 loader program");
      boot_loader = 1'b0;
      issue(2'b01, 2'b00, 18'h00100, 1'b1, "R3 trusted read");
      issue(2'b01, 2'b00, 18'h08780, 1'b0, "R3 window still enforced");

      // R11/R12 wipe keeping window pages
      xo_keep = 1'b1;
      pg_cnt = 0; last_pg = -1; order_bad = 1'b0; saw_xo_pg = 1'b0;
      set_level(2'd0);
      chk(ers_busy && level == 2'd1, "R11 wipe started", 64'({ers_busy, level}), 64'(5));
      issue(2'b00, 2'b00, 18'h00100, 1'b0, "R11 request during wipe");
      set_level(2'd2);
      chk(level == 2'd1, "R11 level held", 64'(level), 1);
      wait_idle();
      chk(level == 2'd0, "R11 level opened", 64'(level), 0);
      chk(ers_done, "R11 done", 64'(ers_done), 1);
      chk(pg_cnt == 126, "R12 kept pages count", 64'(pg_cnt), 126);
      chk(!saw_xo_pg, "R12 window pages skipped", 64'(saw_xo_pg), 0);
      chk(!order_bad, "R11 page order", 64'(order_bad), 0);

      // R12 full wipe without keep
      set_level(2'd1);
      xo_keep = 1'b0;
      pg_cnt = 0; last_pg = -1; order_bad = 1'b0; saw_xo_pg = 1'b0;
      set_level(2'd0);
      chk(!ers_done, "R11 done cleared", 64'(ers_done), 0);
      wait_idle();
      chk(pg_cnt == 128, "R12 all pages", 64'(pg_cnt), 128);
      chk(saw_xo_pg && !order_bad, "R12 window pages erased", 64'({saw_xo_pg, order_bad}), 64'(2));
      chk(level == 2'd0 && ers_done, "R11 open after full wipe", 64'({level, ers_done}), 64'(1));

      // R4 sealed level
      xo_lo = 15'd1; xo_hi = 15'd0;
      set_level(2'd2);
      chk(level == 2'd2, "R5 raise to 2", 64'(level), 2);
      issue(2'b11, 2'b00, 18'h00100, 1'b0, "R4 debug read sealed");
      dbg_attached = 1'b1; boot_ram = 1'b1; boot_loader = 1'b1;
      issue(2'b01, 2'b00, 18'h00100, 1'b1, "R4 context ignored read");
      issue(2'b10, 2'b01, 18'h00200, 1'b1, "R4 context ignored program");
      dbg_attached = 1'b0; boot_ram = 1'b0; boot_loader = 1'b0;
      set_level(2'd0);
      chk(level == 2'd2 && !ers_busy, "R5 sealed no lower", 64'({level, ers_busy}), 64'(4));
      set_level(2'd1);
      chk(level == 2'd2, "R5 sealed no change", 64'(level), 2);

      repeat (4) @(negedge clk);
      #3;
      chk(sbq.size() == 0, "scoreboard drained", 64'(sbq.size()), 0);
      if (!finished) begin
         finished = 1'b1;
         summary();
      end
   end
endmodule